// File: doc/BRIEF.md
# Endian-Selectable Byte/Word Memory Port

This block adapts a core's load/store requests to a memory whose data path is one word wide. A request carries a byte address, an access size (a single byte or a full word), store data, a load sign flag and a runtime endianness select. In the request cycle the block presents the word index, one write enable per byte lane and store data with the byte placed on every lane. The memory is expected to commit writes and register its read word on the next clock edge.

For loads the block remembers the lane, the size and the sign flag. In the following cycle it picks the addressed byte out of the returned word and extends it to the full width, or it passes a whole word through unchanged. A word request whose low address bits are not zero is refused. It writes nothing, returns no data and raises an error flag one cycle later.

Top module: `endian_mem_port`

## Requirements
- R1: `mem_addr` equals the request address shifted right by two (the byte offset is dropped) in the same cycle as the request.
- R2: With `big_endian`=0, the byte at offset k (address bits 1..0) uses lane k, meaning data bits 8k+7..8k and write enable bit k.
- R3: With `big_endian`=1, the byte at offset k uses lane 3-k, so offset 0 maps to bits 31..24 and offset 3 maps to bits 7..0.
- R4: A byte store (`req_size`=0) raises exactly one bit of `mem_we` and drives `mem_wdata` with the low byte of `req_wdata` copied onto all four lanes.
- R5: An aligned word store (`req_size`=1, address bits 1..0 = 0) raises all four write enables and passes `req_wdata` through unchanged, whatever `big_endian` is. With no valid store request, `mem_we` is zero.
- R6: A word request with nonzero address bits 1..0 raises no write enable. It pulses `align_err` in the next cycle, produces no `rd_valid`, and leaves memory contents unchanged.
- R7: A byte load returns the selected byte sign-extended to 32 bits when `req_unsigned`=0, and zero-extended when `req_unsigned`=1.
- R8: An aligned word load returns the stored word unchanged, whatever `big_endian` is.
- R9: `rd_valid` pulses for exactly the cycle after each accepted load, with `rd_data` valid in that cycle. It never pulses for stores.
- R10: While `rst` is high and in the first cycle after it, `rd_valid` and `align_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 1 | 0 = byte, 1 = word |
| req_unsigned | input | 1 | Zero-extend byte loads |
| big_endian | input | 1 | Byte lane numbering select |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data (byte stores use bits 7..0) |
| mem_addr | output | ADDR_W-2 | Word index to memory |
| mem_we | output | DATA_W/8 | Per-lane write enables |
| mem_wdata | output | DATA_W | Lane-placed store data |
| mem_rdata | input | DATA_W | Registered read word from memory |
| rd_data | output | DATA_W | Formatted load result |
| rd_valid | output | 1 | Load result valid |
| align_err | output | 1 | Misaligned word request seen last cycle |

## Verification
The memory-side outputs (`mem_addr`, `mem_we`, `mem_wdata`) are combinational from the request. The bench therefore checks them a short delay after it drives the request on the falling edge, before the rising edge that commits the write. `rd_valid`, `rd_data` and `align_err` belong to the cycle after the request. They are sampled one time unit after that rising edge, when the bench's registered memory model has already produced the read word. Expected load values come from a shadow word array that the bench updates with its own lane formula whenever a store is accepted. A refused store therefore shows up as a mismatch on a later load of the same word.

// File: rtl/emp_pkg.sv
package emp_pkg;
  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/emp_lane_sel.sv
module emp_lane_sel #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             big_endian,
  output logic [OFF_W-1:0] lane,
  output logic [LANES-1:0] lane_oh
);
  localparam logic [OFF_W-1:0] TOP_LANE = OFF_W'(LANES - 1);

  always_comb begin
    lane    = big_endian ? (TOP_LANE - offset) : offset;
    lane_oh = LANES'(1) << lane;
  end
endmodule

// File: rtl/emp_load_fmt.sv
module emp_load_fmt #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [OFF_W-1:0]  lane,
  input  logic              is_word,
  input  logic              zero_ext,
  output logic [DATA_W-1:0] data_out
);
  logic [7:0] lane_bytes [LANES];
  logic [7:0] picked;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane_bytes[g] = word_in[8*g +: 8];
  end

  always_comb begin
    picked = lane_bytes[lane];
    if (is_word)
      data_out = word_in;
    else if (zero_ext)
      data_out = {{(DATA_W-8){1'b0}}, picked};
    else
      data_out = {{(DATA_W-8){picked[7]}}, picked};
  end
endmodule

// File: rtl/endian_mem_port.sv
module endian_mem_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_size,
  input  logic               req_unsigned,
  input  logic               big_endian,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]   mem_we,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               align_err
);
  import emp_pkg::*;

  acc_size_e        size_e;
  logic [OFF_W-1:0] offset;
  logic [OFF_W-1:0] lane;
  logic [LANES-1:0] lane_oh;
  logic             is_word;
  logic             misalign;

  logic             ld_pend_q;
  logic             err_q;
  logic [OFF_W-1:0] lane_q;
  logic             word_q;
  logic             uns_q;

  assign size_e   = acc_size_e'(req_size);
  assign offset   = req_addr[OFF_W-1:0];
  assign is_word  = (size_e == SZ_WORD);
  assign misalign = is_word && (offset != '0);

  emp_lane_sel #(.LANES(LANES)) u_lane (
    .offset    (offset),
    .big_endian(big_endian),
    .lane      (lane),
    .lane_oh   (lane_oh)
  );

  always_comb begin
    mem_addr  = req_addr[ADDR_W-1:OFF_W];
    mem_wdata = is_word ? req_wdata : {LANES{req_wdata[7:0]}};
    if (req_valid && req_write && !misalign)
      mem_we = is_word ? {LANES{1'b1}} : lane_oh;
    else
      mem_we = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_pend_q <= 1'b0;
      err_q     <= 1'b0;
      lane_q    <= '0;
      word_q    <= 1'b0;
      uns_q     <= 1'b0;
    end else begin
      ld_pend_q <= req_valid && !req_write && !misalign;
      err_q     <= req_valid && misalign;
      if (req_valid) begin
        lane_q <= lane;
        word_q <= is_word;
        uns_q  <= req_unsigned;
      end
    end
  end

  emp_load_fmt #(.DATA_W(DATA_W)) u_fmt (
    .word_in (mem_rdata),
    .lane    (lane_q),
    .is_word (word_q),
    .zero_ext(uns_q),
    .data_out(rd_data)
  );

  assign rd_valid  = ld_pend_q;
  assign align_err = err_q;

  p_byte_we_one_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !is_word) |-> ($countones(mem_we) == 1));

  p_idle_no_we_r5: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |-> (mem_we == '0));

  p_misalign_no_we_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && misalign) |-> (mem_we == '0));

  p_misalign_err_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && misalign) |=> (align_err && !rd_valid));

  p_rdv_after_load_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !req_write));

  p_store_no_rdv_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rd_valid);
endmodule

// File: tb/sim_endian_mem_port.sv
module sim_endian_mem_port;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int WORDS = 1 << (AW - 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic          req_unsigned = 1'b0, big_endian = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [AW-3:0] mem_addr;
  logic [3:0]    mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata, rd_data;
  logic          rd_valid, align_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] shadow [WORDS];

  always #4 clk = ~clk;

  endian_mem_port #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_unsigned(req_unsigned), .big_endian(big_endian),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .align_err(align_err)
  );

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (mem_we[k]) mem[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
    mem_rdata <= mem[mem_addr];
  end

  function automatic int lane_of(bit be, logic [1:0] off);
    return be ? 3 - int'(off) : int'(off);
  endfunction

  function automatic logic [DW-1:0] exp_load(bit sz, bit uns, bit be, logic [AW-1:0] a);
    logic [DW-1:0] w;
    logic [7:0] b;
    w = shadow[a[AW-1:2]];
    if (sz) return w;
    b = w[8*lane_of(be, a[1:0]) +: 8];
    return uns ? {24'h0, b} : {{24{b[7]}}, b};
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(bit wr, bit sz, bit uns, bit be, logic [AW-1:0] a, logic [DW-1:0] wd);
    bit mis;
    int ln;
    logic [DW-1:0] el;
    mis = sz && (a[1:0] != 2'b00);
    ln = lane_of(be, a[1:0]);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_unsigned = uns;
    big_endian = be; req_addr = a; req_wdata = wd;
    #1;
    chk("R1 mem_addr", DW'(mem_addr), DW'(a[AW-1:2]));
    if (wr) begin
      if (mis) chk("R6 no write enable", DW'(mem_we), 32'h0);
      else if (sz) begin
        chk("R5 word we", DW'(mem_we), 32'hF);
        chk("R5 word wdata", mem_wdata, wd);
      end else begin
        chk(be ? "R3 byte we big" : "R2 byte we little", DW'(mem_we), DW'(4'b0001 << ln));
        chk("R4 byte replicated", mem_wdata, {4{wd[7:0]}});
      end
    end
    el = exp_load(sz, uns, be, a);
    @(posedge clk);
    if (wr && !mis) begin
      if (sz) shadow[a[AW-1:2]] = wd;
      else shadow[a[AW-1:2]][8*ln +: 8] = wd[7:0];
    end
    #1;
    chk("R6 align_err", DW'(align_err), DW'(mis));
    chk("R9 rd_valid", DW'(rd_valid), DW'(!wr && !mis));
    if (!wr && !mis)
      chk(sz ? "R8 word load" : "R7 byte load", rd_data, el);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R10 rd_valid in reset", DW'(rd_valid), 0);
    chk("R10 align_err in reset", DW'(align_err), 0);
    @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    chk("R10 rd_valid after reset", DW'(rd_valid), 0);
    chk("R5 idle we", DW'(mem_we), 0);

    // R2: little-endian bytes then word read
    for (int k = 0; k < 4; k++) do_op(1, 0, 0, 0, AW'(8'h10 + k), 32'h11 * (k + 1));
    do_op(0, 1, 0, 0, 8'h10, 0);
    chk("R2 little word layout", shadow[4], 32'h44332211);
    // R3: big-endian bytes
    for (int k = 0; k < 4; k++) do_op(1, 0, 0, 1, AW'(8'h20 + k), 32'h11 * (k + 1));
    do_op(0, 1, 0, 0, 8'h20, 0);
    chk("R3 big word layout", shadow[8], 32'h11223344);
    // R8: word load same under both modes
    do_op(1, 1, 0, 1, 8'h30, 32'hA1B2C3D4);
    do_op(0, 1, 0, 0, 8'h30, 0);
    do_op(0, 1, 0, 1, 8'h30, 0);
    // R7: sign and zero extension
    do_op(1, 0, 0, 0, 8'h41, 32'h0000_0080);
    do_op(0, 0, 0, 0, 8'h41, 0);
    do_op(0, 0, 1, 0, 8'h41, 0);
    do_op(0, 0, 0, 1, 8'h42, 0);
    // R6: misaligned word store and load, memory untouched
    do_op(1, 1, 0, 0, 8'h32, 32'hDEADBEEF);
    do_op(0, 1, 0, 0, 8'h33, 0);
    do_op(0, 1, 0, 0, 8'h30, 0);

    for (int n = 0; n < 400; n++)
      do_op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            AW'($urandom), $urandom);

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule